// File: doc/BRIEF.md
# Soft-Start Reference Ramp Generator

This block produces the digital reference code that a switching regulator's feedback comparator uses during start-up. After enable, the code climbs from zero in equal small steps. Steps are paced by a slow tick, which the block divides down from the system clock. When the code arrives at the regulation value, the block stops ramping and selects a fixed reference at that value. The code is expressed in units of 0.1 mV, so a step of 12 is 1.2 mV and the regulation value of 5000 is 500 mV. The DAC and the comparator that consume the code are outside this block.

While the ramp runs, a start-up flag is raised. The switching controller uses this flag to turn its low-side switch off at every zero crossing of the inductor current, whatever light-load mode is selected. This lets the converter start into an output that already carries a voltage. A second flag reports that the ramp has finished. A synchronous reset or a low enable clears the ramp, and the next enable starts it again from zero.

With a 100 MHz system clock and a 500 kHz tick, the ramp lasts 417 ticks, which is 83,400 clock cycles or about 834 µs.

Top module: `ss_ref_ramp`

## Requirements
- R1: In the cycle after `rst` is sampled high, `ref_code` is 0 and both `ss_active` and `ss_done` are 0.
- R2: While `enable` stays low, `ref_code` stays 0 and both flags stay 0.
- R3: During the ramp, `ref_code` (unit 0.1 mV) changes only by rising exactly 12 (1.2 mV), once per tick.
- R4: Ticks come every DIV = CLK_HZ/TICK_HZ clock cycles. Counting from the edge that first samples `enable` high as edge 1, the first step is visible after edge DIV+1.
- R5: `ref_code` never exceeds 5000 (500 mV). The last step saturates at exactly 5000.
- R6: Once the ramp reaches 5000, `ss_done` is 1, `ss_active` is 0, and `ref_code` is held at 5000 for as long as `enable` stays high.
- R7: `ss_active` is 1 from the cycle after `enable` is first sampled high until the ramp completes. `ss_active` and `ss_done` are never 1 together.
- R8: Sampling `enable` low returns the block to its idle outputs in the next cycle. A later enable restarts the ramp from 0.
- R9: `rst` overrides `enable`. A reset in the middle of the ramp restarts it from 0 once reset is released.
- R10: `ss_done` first rises after edge ceil(5000/12)*DIV+1 = 417*DIV+1, counted from the enabling edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset (power-on reset) |
| enable | input | 1 | Regulator enable; low clears the ramp |
| ref_code | output | REF_W | Reference code in 0.1 mV units |
| ss_active | output | 1 | Ramp in progress; forces zero-cross low-side turn-off |
| ss_done | output | 1 | Ramp finished; fixed reference selected |

## Verification
Some properties are checked by assertions on every cycle: the code never goes past 5000, the code only grows by one step or stays put during the ramp, the two flags are mutually exclusive, a low enable or a reset clears the outputs, the ramp starts after enable, and the held value stays in place once done. Other behaviour can only be seen in the bench's scenarios. That includes the exact tick spacing, the cycle on which the first step appears, the total ramp length, and restarts from zero after a disable or a mid-ramp reset. The bench compares these against an arithmetic model on every cycle of a configuration with a divide-by-4 tick.

// File: rtl/ss_pkg.sv
package ss_pkg;

    // Code unit is 0.1 mV
    localparam int unsigned SS_REF_W_DEF  = 13;
    localparam int unsigned SS_STEP_DEF   = 12;    // 1.2 mV
    localparam int unsigned SS_TARGET_DEF = 5000;  // 500 mV

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_RAMP = 2'd1,
        PH_HOLD = 2'd2
    } ss_phase_e;

    // Saturating increment of the ramp code
    function automatic int unsigned sat_step(input int unsigned cur,
                                             input int unsigned step,
                                             input int unsigned lim);
        int unsigned nxt;
        nxt = cur + step;
        return (nxt >= lim) ? lim : nxt;
    endfunction

    // Ticks needed to reach the limit
    function automatic int unsigned ramp_ticks(input int unsigned step,
                                               input int unsigned lim);
        return (lim + step - 1) / step;
    endfunction

endpackage

// File: rtl/ss_tick_div.sv
module ss_tick_div #(
    parameter int unsigned DIV = 200
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic tick
);
    localparam int unsigned CNT_W = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(DIV - 1);

    generate
        if (DIV <= 1) begin : g_passthru
            assign tick = run;
        end else begin : g_count
            logic [CNT_W-1:0] cnt;
            always_ff @(posedge clk) begin
                if (rst || !run) begin
                    cnt <= '0;
                end else if (cnt == LAST) begin
                    cnt <= '0;
                end else begin
                    cnt <= cnt + 1'b1;
                end
            end
            assign tick = run && (cnt == LAST);
        end
    endgenerate
endmodule

// File: rtl/ss_ramp_acc.sv
module ss_ramp_acc
    import ss_pkg::*;
#(
    parameter int unsigned REF_W  = SS_REF_W_DEF,
    parameter int unsigned STEP   = SS_STEP_DEF,
    parameter int unsigned TARGET = SS_TARGET_DEF
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clear,
    input  logic             step_en,
    output logic [REF_W-1:0] acc,
    output logic             last_step
);
    logic [REF_W-1:0] acc_nxt;

    always_comb begin
        acc_nxt   = REF_W'(sat_step(int'(acc), STEP, TARGET));
        last_step = step_en && (int'(acc) + STEP >= TARGET);
    end

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            acc <= '0;
        end else if (step_en) begin
            acc <= acc_nxt;
        end
    end
endmodule

// File: rtl/ss_phase_ctrl.sv
module ss_phase_ctrl
    import ss_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      enable,
    input  logic      last_step,
    output ss_phase_e phase
);
    ss_phase_e phase_nxt;

    always_comb begin
        phase_nxt = phase;
        if (!enable) begin
            phase_nxt = PH_IDLE;
        end else begin
            unique case (phase)
                PH_IDLE: phase_nxt = PH_RAMP;
                PH_RAMP: if (last_step) phase_nxt = PH_HOLD;
                PH_HOLD: phase_nxt = PH_HOLD;
                default: phase_nxt = PH_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= PH_IDLE;
        end else begin
            phase <= phase_nxt;
        end
    end
endmodule

// File: rtl/ss_ref_ramp.sv
module ss_ref_ramp
    import ss_pkg::*;
#(
    parameter int unsigned CLK_HZ  = 100_000_000,
    parameter int unsigned TICK_HZ = 500_000,
    parameter int unsigned REF_W   = SS_REF_W_DEF,
    parameter int unsigned STEP    = SS_STEP_DEF,
    parameter int unsigned TARGET  = SS_TARGET_DEF
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             enable,
    output logic [REF_W-1:0] ref_code,
    output logic             ss_active,
    output logic             ss_done
);
    localparam int unsigned DIV = (CLK_HZ / TICK_HZ > 0) ? CLK_HZ / TICK_HZ : 1;
    localparam logic [REF_W-1:0] FIXED_REF = REF_W'(TARGET);

    ss_phase_e        phase;
    logic             tick;
    logic             last_step;
    logic [REF_W-1:0] ramp_val;
    logic             in_ramp;

    assign in_ramp = (phase == PH_RAMP);

    ss_tick_div #(.DIV(DIV)) u_div (
        .clk  (clk),
        .rst  (rst),
        .run  (in_ramp),
        .tick (tick)
    );

    ss_ramp_acc #(.REF_W(REF_W), .STEP(STEP), .TARGET(TARGET)) u_acc (
        .clk       (clk),
        .rst       (rst),
        .clear     (!enable),
        .step_en   (tick),
        .acc       (ramp_val),
        .last_step (last_step)
    );

    ss_phase_ctrl u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .enable    (enable),
        .last_step (last_step),
        .phase     (phase)
    );

    // Hand-over: the fixed reference replaces the ramp once complete
    always_comb begin
        ref_code  = (phase == PH_HOLD) ? FIXED_REF : ramp_val;
        ss_active = in_ramp;
        ss_done   = (phase == PH_HOLD);
    end
endmodule

// File: rtl/ss_ref_ramp_chk.sv
module ss_ref_ramp_chk #(
    parameter int unsigned REF_W  = 13,
    parameter int unsigned STEP   = 12,
    parameter int unsigned TARGET = 5000
) (
    input logic             clk,
    input logic             rst,
    input logic             enable,
    input logic [REF_W-1:0] ref_code,
    input logic             ss_active,
    input logic             ss_done
);
    localparam logic [REF_W-1:0] TGT = REF_W'(TARGET);
    localparam logic [REF_W-1:0] STP = REF_W'(STEP);

    // R1
    p_reset_idle_r1: assert property (@(posedge clk)
        rst |=> (ref_code == '0 && !ss_active && !ss_done));

    // R3
    p_step_only_r3: assert property (@(posedge clk) disable iff (rst)
        (ss_active && enable) |=> (ref_code == $past(ref_code) ||
                                   ref_code == $past(ref_code) + STP ||
                                   ref_code == TGT));

    // R5
    p_no_overflow_r5: assert property (@(posedge clk) disable iff (rst)
        ref_code <= TGT);

    // R6
    p_hold_r6: assert property (@(posedge clk) disable iff (rst)
        (ss_done && enable) |=> (ss_done && ref_code == TGT));

    // R7
    p_exclusive_r7: assert property (@(posedge clk) disable iff (rst)
        !(ss_active && ss_done));

    // R7
    p_start_r7: assert property (@(posedge clk) disable iff (rst)
        (enable && !ss_active && !ss_done) |=> ss_active);

    // R8
    p_clear_r8: assert property (@(posedge clk) disable iff (rst)
        !enable |=> (ref_code == '0 && !ss_active && !ss_done));
endmodule

bind ss_ref_ramp ss_ref_ramp_chk #(
    .REF_W  (REF_W),
    .STEP   (STEP),
    .TARGET (TARGET)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .enable    (enable),
    .ref_code  (ref_code),
    .ss_active (ss_active),
    .ss_done   (ss_done)
);

// File: tb/ss_ref_ramp_tb.sv
`timescale 1ns/1ps
module ss_ref_ramp_tb;
    localparam int CLK_HZ  = 2_000_000;
    localparam int TICK_HZ = 500_000;
    localparam int DIV     = CLK_HZ / TICK_HZ;
    localparam int REF_W   = 13;
    localparam int STEP    = 12;
    localparam int TARGET  = 5000;
    localparam int NTICKS  = (TARGET + STEP - 1) / STEP;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             enable = 1'b0;
    logic [REF_W-1:0] ref_code;
    logic             ss_active;
    logic             ss_done;

    int tests = 0;
    int fails = 0;
    int n = 0;
    int cyc = 0;
    int done_edge = -1;
    logic prev_done = 1'b0;
    logic finished = 1'b0;

    always #2 clk = ~clk;

    ss_ref_ramp #(
        .CLK_HZ(CLK_HZ), .TICK_HZ(TICK_HZ), .REF_W(REF_W),
        .STEP(STEP), .TARGET(TARGET)
    ) u_dut (
        .clk(clk), .rst(rst), .enable(enable),
        .ref_code(ref_code), .ss_active(ss_active), .ss_done(ss_done)
    );

    // Edges since enable (arithmetic model from the requirements)
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (rst || !enable) n <= 0;
        else n <= n + 1;
    end

    function automatic int exp_ref(input int e);
        int v;
        if (e == 0) return 0;
        v = ((e - 1) / DIV) * STEP;
        return (v >= TARGET) ? TARGET : v;
    endfunction

    function automatic logic exp_done(input int e);
        return (e > 0) && (((e - 1) / DIV) * STEP >= TARGET);
    endfunction

    task automatic check(input string req, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d (edge %0d)", req, act, exp, n);
        end
    endtask

    // Per-cycle comparison against the model
    always @(negedge clk) begin
        if (!finished) begin
            string tag;
            tag = (n == 0) ? "R2" : exp_done(n) ? "R6" : (n <= 2 * DIV) ? "R4" : "R3";
            check(tag, int'(ref_code), exp_ref(n));
            check(tag, int'(ss_done), int'(exp_done(n)));
            check("R7", int'(ss_active), int'(n > 0 && !exp_done(n)));
            check("R7", int'(ss_active && ss_done), 0);
            if (int'(ref_code) > TARGET) check("R5", int'(ref_code), TARGET);
            if (ss_done && !prev_done) done_edge = n;
            prev_done = ss_done;
        end
    end

    task automatic cycles(input int k);
        for (int i = 0; i < k; i++) @(negedge clk);
        #1;
    endtask

    initial begin
        cycles(3);
        check("R1", int'(ref_code), 0);
        check("R1", int'(ss_active || ss_done), 0);
        rst = 1'b0;
        cycles(10);
        check("R2", int'(ref_code), 0);

        // Full ramp and hold
        enable = 1'b1;
        cycles(NTICKS * DIV + 40);
        check("R10", done_edge, NTICKS * DIV + 1);
        check("R5", int'(ref_code), TARGET);
        check("R6", int'(ss_done), 1);

        // Disable, then restart
        enable = 1'b0;
        cycles(1);
        check("R8", int'(ref_code), 0);
        check("R8", int'(ss_done || ss_active), 0);
        cycles(4);
        enable = 1'b1;
        cycles(300);
        check("R8", int'(ref_code), exp_ref(300));
        enable = 1'b0;
        cycles(1);
        check("R8", int'(ref_code), 0);
        enable = 1'b1;
        cycles(200);
        check("R8", int'(ref_code), exp_ref(200));

        // Reset mid-ramp with enable held high
        rst = 1'b1;
        cycles(2);
        check("R9", int'(ref_code), 0);
        check("R9", int'(ss_active), 0);
        rst = 1'b0;
        done_edge = -1;
        cycles(NTICKS * DIV + 10);
        check("R9", done_edge, NTICKS * DIV + 1);
        check("R5", int'(ref_code), TARGET);

        finished = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    // Watchdog
    always @(posedge clk) begin
        if (cyc > 100_000 && !finished) begin
            finished = 1'b1;
            tests++;
            fails++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule